// File: doc/BRIEF.md
# Mesh Router Input Port

This block is one input port of a five-port router in a two-dimensional mesh. Flits arrive with a valid strobe and are held in a first-in first-out buffer whose depth is a parameter. The flit at the front of the buffer is offered to the switch scheduler together with a one-hot request naming the output port it must leave by. The scheduler answers with a pop strobe when it has taken that flit.

The request is computed from the destination coordinates carried in the header flit. Routing is dimension-ordered: the X offset is resolved first, then the Y offset, and the local port is chosen when both match the router's own coordinates, which are parameters. Switching is wormhole: the route picked at the header stays in force for every flit of the packet until the tail flit has been popped. A nearly-full flag goes back to the upstream sender so that it can stall before the buffer overflows. A flit that arrives while the buffer is full is dropped and sets a sticky error flag.

Top module: `mesh_inport`

## Requirements
- R1: After reset the buffer is empty: `head_valid`, `req`, `nearly_full` and `overflow_err` are all 0.
- R2: Flits leave in the order they were accepted. `head_flit` shows the oldest stored flit, and `head_valid` is 1 exactly when at least one flit is stored.
- R3: `nearly_full` is 1 exactly when DEPTH-1 or more flits are stored.
- R4: A flit presented while DEPTH flits are stored is discarded and the stored flits are unchanged. `overflow_err` then becomes 1 and stays 1 until reset.
- R5: A pop while the buffer is empty has no effect.
- R6: Flit bit 19 is the tail flag, bits 18:16 the destination X and bits 15:13 the destination Y. The request bits are 0 Local, 1 North, 2 South, 3 East, 4 West. A destination X above the router's X requests East and below it requests West. Only when X matches is Y used: a larger Y requests South and a smaller Y requests North.
- R7: When destination X and Y both equal the router's coordinates, the request is Local.
- R8: The route computed from a header flit is held for every following flit of the packet. The destination fields of body flits are ignored.
- R9: Popping a flit with the tail flag set ends the packet, so the next flit is routed as a fresh header. A header that also carries the tail flag forms a one-flit packet.
- R10: `req` is at most one-hot and is all zero while the buffer is empty.
- R11: A push and a pop in the same cycle on a non-full buffer keep the occupancy unchanged and keep the flit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_in | input | 20 | Incoming flit |
| flit_valid | input | 1 | Write strobe for `flit_in` |
| pop | input | 1 | Scheduler took the head flit |
| head_flit | output | 20 | Oldest stored flit |
| head_valid | output | 1 | Buffer not empty |
| req | output | 5 | One-hot output-port request |
| nearly_full | output | 1 | Early stall warning to upstream |
| overflow_err | output | 1 | Sticky flag for a flit dropped while full |

## Verification
The bench sends a one-flit packet to each of the 64 destinations and compares the request against an arithmetic XY decision. A router that checked Y before X, or that swapped the East/West or North/South sense, would fail many of these points. It fills the buffer one flit at a time to catch a nearly-full threshold that is off by one. It then overfills the buffer and drains it to see whether a dropped flit overwrote stored data or failed to set the sticky error flag. A multi-flit packet whose body flits carry conflicting destinations shows whether a design re-routes in mid-packet instead of holding the route. The flit that follows the tail shows whether the held route is released at the end of the packet. Same-cycle push and pop on a partly full buffer catches occupancy that drifts.

// File: rtl/inport_pkg.sv
package inport_pkg;
    localparam int FLIT_W    = 20;
    localparam int COORD_W   = 3;
    localparam int TAIL_BIT  = 19;
    localparam int DX_LSB    = 16;
    localparam int DY_LSB    = 13;
    localparam int NUM_PORTS = 5;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_SOUTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;
endpackage

// File: rtl/inport_fifo.sv
module inport_fifo #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             not_empty,
    output logic             almost_full,
    output logic             err_flag,
    output logic [CNT_W-1:0] occupancy
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             err;
    } fifo_state_t;

    fifo_state_t      st_d, st_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             full, empty, do_wr, do_rd;

    always_comb begin
        full  = (st_q.count == CNT_W'(DEPTH));
        empty = (st_q.count == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;

        st_d  = st_q;
        mem_d = mem_q;

        if (do_wr) begin
            mem_d[st_q.wr_ptr] = wr_data;
            if (st_q.wr_ptr == PTR_W'(DEPTH - 1)) st_d.wr_ptr = '0;
            else                                  st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (do_rd) begin
            if (st_q.rd_ptr == PTR_W'(DEPTH - 1)) st_d.rd_ptr = '0;
            else                                  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        if (wr_en && full) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data     = mem_q[st_q.rd_ptr];
    assign not_empty   = !empty;
    assign almost_full = (st_q.count >= CNT_W'(DEPTH - 1));
    assign err_flag    = st_q.err;
    assign occupancy   = st_q.count;
endmodule

// File: rtl/inport_xy_route.sv
module inport_xy_route
    import inport_pkg::*;
#(
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic [COORD_W-1:0]   dest_x,
    input  logic [COORD_W-1:0]   dest_y,
    output logic [NUM_PORTS-1:0] route_oh
);
    port_e sel;

    always_comb begin
        if (dest_x > COORD_W'(MY_X))      sel = PORT_EAST;
        else if (dest_x < COORD_W'(MY_X)) sel = PORT_WEST;
        else if (dest_y > COORD_W'(MY_Y)) sel = PORT_SOUTH;
        else if (dest_y < COORD_W'(MY_Y)) sel = PORT_NORTH;
        else                              sel = PORT_LOCAL;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
        assign route_oh[g] = (sel == port_e'(g));
    end
endmodule

// File: rtl/inport_route_hold.sv
module inport_route_hold
    import inport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 head_valid,
    input  logic                 head_tail,
    input  logic                 pop_ok,
    input  logic [NUM_PORTS-1:0] route_new,
    output logic [NUM_PORTS-1:0] req
);
    typedef struct packed {
        logic                 in_pkt;
        logic [NUM_PORTS-1:0] route;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic [NUM_PORTS-1:0] route_now;

    always_comb begin
        route_now = st_q.in_pkt ? st_q.route : route_new;
        st_d      = st_q;
        if (pop_ok) begin
            if (head_tail) begin
                st_d.in_pkt = 1'b0;
            end else begin
                st_d.in_pkt = 1'b1;
                st_d.route  = route_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = head_valid ? route_now : '0;
endmodule

// File: rtl/mesh_inport.sv
module mesh_inport
    import inport_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int MY_X  = 2,
    parameter int MY_Y  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLIT_W-1:0]    flit_in,
    input  logic                 flit_valid,
    input  logic                 pop,
    output logic [FLIT_W-1:0]    head_flit,
    output logic                 head_valid,
    output logic [NUM_PORTS-1:0] req,
    output logic                 nearly_full,
    output logic                 overflow_err
);
    logic [CNT_W-1:0]     occ;
    logic [NUM_PORTS-1:0] route_new;

    inport_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (flit_in),
        .wr_en      (flit_valid),
        .rd_en      (pop),
        .rd_data    (head_flit),
        .not_empty  (head_valid),
        .almost_full(nearly_full),
        .err_flag   (overflow_err),
        .occupancy  (occ)
    );

    inport_xy_route #(.MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dest_x  (head_flit[DX_LSB +: COORD_W]),
        .dest_y  (head_flit[DY_LSB +: COORD_W]),
        .route_oh(route_new)
    );

    inport_route_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_valid(head_valid),
        .head_tail (head_flit[TAIL_BIT]),
        .pop_ok    (pop && head_valid),
        .route_new (route_new),
        .req       (req)
    );
endmodule

// File: rtl/inport_checker.sv
module inport_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flit_valid,
    input logic             pop,
    input logic             head_valid,
    input logic [4:0]       req,
    input logic             nearly_full,
    input logic             overflow_err,
    input logic [CNT_W-1:0] occ
);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);
    assert_nf_falls_on_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nearly_full && !pop |=> nearly_full);
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid && pop && !flit_valid |=> !head_valid);
    assert_req_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    assert_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> req == 5'd0);
    assert_route_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid && !pop |=> $stable(req));
endmodule

bind mesh_inport inport_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flit_valid  (flit_valid),
    .pop         (pop),
    .head_valid  (head_valid),
    .req         (req),
    .nearly_full (nearly_full),
    .overflow_err(overflow_err),
    .occ         (occ)
);

// File: tb/mesh_inport_bench.sv
module mesh_inport_bench;
    localparam int DEPTH = 4;
    localparam int MX = 2;
    localparam int MY = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [19:0] flit_in = '0;
    logic        flit_valid = 0;
    logic        pop = 0;
    logic [19:0] head_flit;
    logic        head_valid;
    logic [4:0]  req;
    logic        nearly_full;
    logic        overflow_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mesh_inport #(.DEPTH(DEPTH), .MY_X(MX), .MY_Y(MY)) u_mesh_inport (
        .clk(clk), .rst_n(rst_n), .flit_in(flit_in), .flit_valid(flit_valid),
        .pop(pop), .head_flit(head_flit), .head_valid(head_valid), .req(req),
        .nearly_full(nearly_full), .overflow_err(overflow_err)
    );

    function automatic logic [19:0] mk(input bit t, input int x, input int y, input int pl);
        return {t, 3'(x), 3'(y), 5'd0, 8'(pl)};
    endfunction

    function automatic logic [4:0] exp_route(input int x, input int y);
        if (x > MX) return 5'b01000;
        if (x < MX) return 5'b10000;
        if (y > MY) return 5'b00100;
        if (y < MY) return 5'b00010;
        return 5'b00001;
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [19:0] f);
        flit_in = f; flit_valid = 1; tick(); flit_valid = 0;
    endtask

    task automatic pop1();
        pop = 1; tick(); pop = 0;
    endtask

    task automatic reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        reset();
        // R1 reset state
        check("R1", "head_valid", 32'(head_valid), 0);
        check("R1", "req", 32'(req), 0);
        check("R1", "nearly_full", 32'(nearly_full), 0);
        check("R1", "overflow_err", 32'(overflow_err), 0);

        // R5 pop on empty
        pop1();
        check("R5", "empty after pop", 32'(head_valid), 0);
        push(mk(1, MX, MY, 8'h5a));
        check("R5", "head after empty pop", 32'(head_flit), 32'(mk(1, MX, MY, 8'h5a)));
        pop1();

        // R6 R7 R9 sweep of all destinations as one-flit packets
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < 8; y++) begin
                push(mk(1, x, y, x * 8 + y));
                if (x == MX && y == MY) check("R7", "local", 32'(req), 32'(exp_route(x, y)));
                else                    check("R6", "xy route", 32'(req), 32'(exp_route(x, y)));
                pop1();
                check("R9", "released after tail", 32'(req), 0);
            end
        end

        // R3 nearly-full threshold, R2 order, R4 overflow
        for (int k = 1; k <= DEPTH; k++) begin
            push(mk(1, MX, MY, 16 + k));
            check("R3", "nearly_full", 32'(nearly_full), 32'(k >= DEPTH - 1));
        end
        check("R4", "no error before overflow", 32'(overflow_err), 0);
        push(mk(1, MX, MY, 8'hee));
        check("R4", "error set", 32'(overflow_err), 1);
        for (int k = 1; k <= DEPTH; k++) begin
            check("R2", "order", 32'(head_flit), 32'(mk(1, MX, MY, 16 + k)));
            pop1();
            check("R3", "nearly_full drain", 32'(nearly_full), 32'(DEPTH - k >= DEPTH - 1));
        end
        check("R4", "dropped flit absent", 32'(head_valid), 0);
        check("R4", "error sticky", 32'(overflow_err), 1);

        // R11 simultaneous push and pop
        push(mk(1, MX, MY, 1));
        push(mk(1, MX, MY, 2));
        flit_in = mk(1, MX, MY, 3); flit_valid = 1; pop = 1; tick(); flit_valid = 0; pop = 0;
        check("R11", "head after push+pop", 32'(head_flit), 32'(mk(1, MX, MY, 2)));
        check("R11", "occupancy not near full", 32'(nearly_full), 0);
        pop1();
        check("R11", "second", 32'(head_flit), 32'(mk(1, MX, MY, 3)));
        pop1();
        check("R11", "drained", 32'(head_valid), 0);

        // R8 wormhole hold
        push(mk(0, 5, 3, 1));
        push(mk(0, 0, 0, 2));
        push(mk(0, MX, 7, 3));
        push(mk(1, 0, 7, 4));
        check("R8", "header route", 32'(req), 32'(5'b01000));
        for (int k = 0; k < 3; k++) begin
            pop1();
            check("R8", "body route held", 32'(req), 32'(5'b01000));
        end
        pop1();
        check("R10", "empty req zero", 32'(req), 0);
        push(mk(0, MX, 0, 9));
        check("R9", "fresh header", 32'(req), 32'(5'b00010));
        pop1();
        push(mk(1, 7, 7, 10));
        check("R8", "body ignores fields", 32'(req), 32'(5'b00010));
        pop1();
        check("R9", "tail ends packet", 32'(req), 0);
        check("R4", "still sticky", 32'(overflow_err), 1);

        reset();
        check("R1", "error cleared by reset", 32'(overflow_err), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule